// File: doc/BRIEF.md
# Virtual Interrupt List Register Bank

This block holds a small set of list entries through which a hypervisor hands virtual interrupts to a guest CPU interface. Every entry carries a virtual interrupt number, a two-bit lifecycle state, a flag that ties the entry to a real interrupt line, and the number of that physical line. The host side programs an entry and reads it back. The guest side consumes entries in two ways. An acknowledge returns the number of a waiting interrupt and moves that entry to the active state. A deactivate, given by interrupt number, retires an entry that is in service.

Tied entries let the guest's completion reach the physical interrupt controller directly. When the guest deactivates a tied entry, the bank emits a one-cycle request that carries the physical number, so the real line is released without a trip through the host. A physical interrupt that is forwarded to the guest is shown as pending, because pending is the only state the guest interface presents as a new interrupt. For that reason a tied entry may hold pending or active, but never both at once.

Top module: `vint_lr_bank`

## Requirements
- R1: After reset every entry reads inactive with zero fields, `guest_ack_id` is all ones, and `host_wr_err`, `phys_deact_vld` and `deact_miss` are low.
- R2: The state field encodes 00 as inactive, 01 as pending, 10 as active and 11 as pending+active. An accepted host write replaces all four fields of entry `host_idx` at the clock edge. `host_rd_*` show the current contents of entry `host_rd_idx` without delay.
- R3: `guest_ack_id` shows, without delay, the virtual number of the lowest-indexed entry whose state is exactly pending (01). When `guest_ack` is high, that entry becomes active (10) at the clock edge.
- R4: When no entry is in state 01, `guest_ack_id` reads all ones and an acknowledge changes no entry.
- R5: A host write that has the link bit set and state 11 is rejected. The entry keeps its old contents, and `host_wr_err` is high for exactly the following cycle. A tied entry never holds state 11.
- R6: A deactivate chooses the lowest-indexed entry that has the active bit (bit 1) set and a virtual number equal to `guest_deact_id`. State 10 becomes 00, and state 11 becomes 01.
- R7: When the chosen entry of a deactivate is tied, `phys_deact_vld` is high for the next cycle, with that entry's physical number on `phys_deact_id`. An untied entry produces no request.
- R8: A deactivate that matches no entry changes no entry and sets `deact_miss`, which stays high until reset.
- R9: All guest operations in a cycle are judged on the contents from before the edge. Both an acknowledge and a deactivate may take effect in the same cycle. When a host write hits the same entry as a guest operation, the host contents win, while the guest operation's outputs still follow the contents from before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr_en | input | 1 | Host write strobe |
| host_idx | input | 2 | Entry written by the host |
| host_wr_vid | input | 10 | Virtual number to store |
| host_wr_state | input | 2 | State to store |
| host_wr_link | input | 1 | Link-to-physical flag to store |
| host_wr_pid | input | 10 | Physical number to store |
| host_wr_err | output | 1 | Pulse: the previous write was rejected |
| host_rd_idx | input | 2 | Entry shown on the read outputs |
| host_rd_vid | output | 10 | Virtual number of the read entry |
| host_rd_state | output | 2 | State of the read entry |
| host_rd_link | output | 1 | Link flag of the read entry |
| host_rd_pid | output | 10 | Physical number of the read entry |
| guest_ack | input | 1 | Guest acknowledge |
| guest_ack_id | output | 10 | Number returned by an acknowledge, all ones if none |
| guest_deact | input | 1 | Guest deactivate strobe |
| guest_deact_id | input | 10 | Virtual number being deactivated |
| phys_deact_vld | output | 1 | Physical deactivate request |
| phys_deact_id | output | 10 | Physical number to deactivate |
| deact_miss | output | 1 | Sticky: a deactivate found no entry |

## Verification
Two collisions receive the most attention. The first is an acknowledge and a deactivate in the same cycle, on different entries and on an entry that is only now being acknowledged, which must count as a miss. The second is a host write that lands on the entry an acknowledge or deactivate selects. The bench forces both with directed sequences, then runs a long stretch of pseudo-random traffic over a narrow range of numbers so that matches and collisions come up often. A behavioural model updates from the contents before each edge, applies the host write last, and is compared with the ports on every clock.

// File: rtl/vint_lr_pkg.sv
package vint_lr_pkg;
   typedef enum logic [1:0] {
      LR_IDLE = 2'b00,
      LR_PEND = 2'b01,
      LR_ACT  = 2'b10,
      LR_BOTH = 2'b11
   } lr_state_e;
endpackage

// File: rtl/vint_lr_first.sv
// Lowest-index request finder, shared by the acknowledge and deactivate paths.
module vint_lr_first #(
   parameter int N = 4,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   output logic [N-1:0]  grant,
   output logic [IW-1:0] idx,
   output logic          any
);
   if (N < 1) begin : g_bad_n
      $error("vint_lr_first: N must be at least 1");
   end

   always_comb begin
      grant = '0;
      idx   = '0;
      any   = 1'b0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            grant    = '0;
            grant[i] = 1'b1;
            idx      = IW'(i);
            any      = 1'b1;
         end
      end
   end

   // R3 / R6: at most one entry is chosen
   always_comb begin
      a_r3_one_grant: assert ($onehot0(grant));
   end
endmodule

// File: rtl/vint_lr_entry.sv
// One list entry: fields plus its state transitions.
module vint_lr_entry
   import vint_lr_pkg::*;
#(
   parameter int ID_W = 10
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [ID_W-1:0] wr_vid,
   input  lr_state_e       wr_state,
   input  logic            wr_link,
   input  logic [ID_W-1:0] wr_pid,
   input  logic            ack_hit,
   input  logic            deact_hit,
   output logic [ID_W-1:0] vid,
   output lr_state_e       state,
   output logic            link,
   output logic [ID_W-1:0] pid
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vid   <= '0;
         state <= LR_IDLE;
         link  <= 1'b0;
         pid   <= '0;
      end else if (wr_en) begin
         vid   <= wr_vid;
         state <= wr_state;
         link  <= wr_link;
         pid   <= wr_pid;
      end else if (ack_hit) begin
         state <= LR_ACT;
      end else if (deact_hit) begin
         state <= (state == LR_BOTH) ? LR_PEND : LR_IDLE;
      end
   end

   a_r3_ack_to_active: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_hit && !wr_en) |=> (state == LR_ACT));

   a_r6_deact_clears_active: assert property (@(posedge clk) disable iff (!rst_n)
      (deact_hit && !wr_en) |=> !state[1]);

   a_r5_linked_never_both: assert property (@(posedge clk) disable iff (!rst_n)
      link |-> (state != LR_BOTH));
endmodule

// File: rtl/vint_lr_bank.sv
module vint_lr_bank
   import vint_lr_pkg::*;
#(
   parameter int NUM_LR = 4,
   parameter int ID_W   = 10,
   localparam int IDX_W = (NUM_LR > 1) ? $clog2(NUM_LR) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             host_wr_en,
   input  logic [IDX_W-1:0] host_idx,
   input  logic [ID_W-1:0]  host_wr_vid,
   input  logic [1:0]       host_wr_state,
   input  logic             host_wr_link,
   input  logic [ID_W-1:0]  host_wr_pid,
   output logic             host_wr_err,
   input  logic [IDX_W-1:0] host_rd_idx,
   output logic [ID_W-1:0]  host_rd_vid,
   output logic [1:0]       host_rd_state,
   output logic             host_rd_link,
   output logic [ID_W-1:0]  host_rd_pid,
   input  logic             guest_ack,
   output logic [ID_W-1:0]  guest_ack_id,
   input  logic             guest_deact,
   input  logic [ID_W-1:0]  guest_deact_id,
   output logic             phys_deact_vld,
   output logic [ID_W-1:0]  phys_deact_id,
   output logic             deact_miss
);
   localparam logic [ID_W-1:0] SPURIOUS = {ID_W{1'b1}};

   if (NUM_LR < 1) begin : g_bad_depth
      $error("vint_lr_bank: NUM_LR must be at least 1");
   end
   if (ID_W < 2) begin : g_bad_width
      $error("vint_lr_bank: ID_W must be at least 2");
   end

   logic [ID_W-1:0] vid_q [NUM_LR];
   lr_state_e       st_q  [NUM_LR];
   logic            lnk_q [NUM_LR];
   logic [ID_W-1:0] pid_q [NUM_LR];

   logic [NUM_LR-1:0] pend_req, act_req, ack_grant, dea_grant;
   logic [IDX_W-1:0]  ack_idx, dea_idx;
   logic              ack_any, dea_any;
   logic              wr_bad;

   assign wr_bad = host_wr_en && host_wr_link && (lr_state_e'(host_wr_state) == LR_BOTH);

   for (genvar i = 0; i < NUM_LR; i++) begin : g_lr
      assign pend_req[i] = (st_q[i] == LR_PEND);
      assign act_req[i]  = st_q[i][1] && (vid_q[i] == guest_deact_id);

      vint_lr_entry #(.ID_W(ID_W)) u_entry (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_en     (host_wr_en && !wr_bad && (host_idx == IDX_W'(i))),
         .wr_vid    (host_wr_vid),
         .wr_state  (lr_state_e'(host_wr_state)),
         .wr_link   (host_wr_link),
         .wr_pid    (host_wr_pid),
         .ack_hit   (guest_ack && ack_grant[i]),
         .deact_hit (guest_deact && dea_grant[i]),
         .vid       (vid_q[i]),
         .state     (st_q[i]),
         .link      (lnk_q[i]),
         .pid       (pid_q[i])
      );
   end

   vint_lr_first #(.N(NUM_LR)) u_ack_pick (
      .req   (pend_req),
      .grant (ack_grant),
      .idx   (ack_idx),
      .any   (ack_any)
   );

   vint_lr_first #(.N(NUM_LR)) u_dea_pick (
      .req   (act_req),
      .grant (dea_grant),
      .idx   (dea_idx),
      .any   (dea_any)
   );

   assign guest_ack_id  = ack_any ? vid_q[ack_idx] : SPURIOUS;
   assign host_rd_vid   = vid_q[host_rd_idx];
   assign host_rd_state = st_q[host_rd_idx];
   assign host_rd_link  = lnk_q[host_rd_idx];
   assign host_rd_pid   = pid_q[host_rd_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         host_wr_err    <= 1'b0;
         phys_deact_vld <= 1'b0;
         phys_deact_id  <= '0;
         deact_miss     <= 1'b0;
      end else begin
         host_wr_err    <= wr_bad;
         phys_deact_vld <= guest_deact && dea_any && lnk_q[dea_idx];
         phys_deact_id  <= pid_q[dea_idx];
         deact_miss     <= deact_miss || (guest_deact && !dea_any);
      end
   end

   a_r7_strobe_needs_deact: assert property (@(posedge clk) disable iff (!rst_n)
      phys_deact_vld |-> $past(guest_deact));

   a_r8_miss_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      deact_miss |=> deact_miss);

   a_r5_err_from_linked_write: assert property (@(posedge clk) disable iff (!rst_n)
      host_wr_err |-> $past(host_wr_en && host_wr_link));
endmodule

// File: tb/vint_lr_bank_bench.sv
module vint_lr_bank_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic       host_wr_en = 0, host_wr_link = 0, guest_ack = 0, guest_deact = 0;
   logic [1:0] host_idx = 0, host_wr_state = 0, host_rd_idx = 0;
   logic [9:0] host_wr_vid = 0, host_wr_pid = 0, guest_deact_id = 0;
   logic       host_wr_err, host_rd_link, phys_deact_vld, deact_miss;
   logic [1:0] host_rd_state;
   logic [9:0] host_rd_vid, host_rd_pid, guest_ack_id, phys_deact_id;

   vint_lr_bank u_vint_lr_bank (
      .clk(clk), .rst_n(rst_n),
      .host_wr_en(host_wr_en), .host_idx(host_idx), .host_wr_vid(host_wr_vid),
      .host_wr_state(host_wr_state), .host_wr_link(host_wr_link), .host_wr_pid(host_wr_pid),
      .host_wr_err(host_wr_err), .host_rd_idx(host_rd_idx), .host_rd_vid(host_rd_vid),
      .host_rd_state(host_rd_state), .host_rd_link(host_rd_link), .host_rd_pid(host_rd_pid),
      .guest_ack(guest_ack), .guest_ack_id(guest_ack_id), .guest_deact(guest_deact),
      .guest_deact_id(guest_deact_id), .phys_deact_vld(phys_deact_vld),
      .phys_deact_id(phys_deact_id), .deact_miss(deact_miss)
   );

   int errors = 0, checks = 0;
   bit finished = 0;
   int m_vid[4], m_st[4], m_lnk[4], m_pid[4];
   int m_err = 0, m_pv = 0, m_ppid = 0, m_miss = 0;
   int rd_ptr = 0;

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < 4; i++) begin
         m_vid[i] = 0; m_st[i] = 0; m_lnk[i] = 0; m_pid[i] = 0;
      end
      m_err = 0; m_pv = 0; m_ppid = 0; m_miss = 0;
   endtask

   // One clock: drive at negedge, check the acknowledge value mid-cycle, step the model, check after the edge
   task automatic cyc(bit ack, bit dea, int did, bit wr, int widx, int wvid, int wst, bit wl, int wpid);
      int ack_e, dea_e, exp_ack;
      bit bad;
      int n_st[4];
      host_wr_en = wr; host_idx = 2'(widx); host_wr_vid = 10'(wvid);
      host_wr_state = 2'(wst); host_wr_link = wl; host_wr_pid = 10'(wpid);
      guest_ack = ack; guest_deact = dea; guest_deact_id = 10'(did);
      #5;
      ack_e = -1; dea_e = -1;
      for (int i = 0; i < 4; i++) begin
         if (ack_e < 0 && m_st[i] == 1) ack_e = i;
         if (dea_e < 0 && m_st[i] >= 2 && m_vid[i] == did) dea_e = i;
      end
      exp_ack = (ack_e >= 0) ? m_vid[ack_e] : 1023;
      chk(ack_e >= 0 ? "R3 ack id" : "R4 spurious id", int'(guest_ack_id), exp_ack);
      for (int i = 0; i < 4; i++) n_st[i] = m_st[i];
      bad = wr && wl && (wst == 3);
      if (ack && ack_e >= 0) n_st[ack_e] = 2;
      if (dea && dea_e >= 0) n_st[dea_e] = (m_st[dea_e] == 3) ? 1 : 0;
      m_pv = (dea && dea_e >= 0 && m_lnk[dea_e] != 0) ? 1 : 0;
      if (m_pv != 0) m_ppid = m_pid[dea_e];
      if (dea && dea_e < 0) m_miss = 1;
      m_err = bad ? 1 : 0;
      for (int i = 0; i < 4; i++) m_st[i] = n_st[i];
      if (wr && !bad) begin   // R9: host write wins over a guest operation on the same entry
         m_vid[widx] = wvid; m_st[widx] = wst; m_lnk[widx] = wl; m_pid[widx] = wpid;
      end
      @(posedge clk);
      #1;
      host_rd_idx = 2'(rd_ptr);
      #1;
      chk("R2 read vid", int'(host_rd_vid), m_vid[rd_ptr]);
      chk("R2 read state (R3 R6 R9)", int'(host_rd_state), m_st[rd_ptr]);
      chk("R2 read link", int'(host_rd_link), m_lnk[rd_ptr]);
      chk("R2 read pid", int'(host_rd_pid), m_pid[rd_ptr]);
      chk("R5 write error pulse", int'(host_wr_err), m_err);
      chk("R7 phys strobe", int'(phys_deact_vld), m_pv);
      if (m_pv != 0) chk("R7 phys id", int'(phys_deact_id), m_ppid);
      chk("R8 miss sticky", int'(deact_miss), m_miss);
      rd_ptr = (rd_ptr + 1) % 4;
      @(negedge clk);
   endtask

   task automatic idle(int n);
      for (int k = 0; k < n; k++) cyc(0, 0, 0, 0, 0, 0, 0, 0, 0);
   endtask

   initial begin
      #4_000_000;
      if (!finished) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      bit [15:0] lfsr;
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #2;
      // R1 reset state
      chk("R1 ack all ones", int'(guest_ack_id), 1023);
      chk("R1 err low", int'(host_wr_err), 0);
      chk("R1 strobe low", int'(phys_deact_vld), 0);
      chk("R1 miss low", int'(deact_miss), 0);
      for (int i = 0; i < 4; i++) begin
         host_rd_idx = 2'(i); #1;
         chk("R1 entry idle", int'(host_rd_state), 0);
      end
      @(negedge clk);
      // R2 programming
      cyc(0, 0, 0, 1, 0, 5, 1, 0, 0);
      cyc(0, 0, 0, 1, 1, 7, 1, 1, 40);
      cyc(0, 0, 0, 1, 2, 9, 2, 1, 33);
      cyc(0, 0, 0, 1, 3, 11, 3, 0, 0);
      idle(4);
      // R3 lowest pending first, R4 spurious when only pending+active remains
      cyc(1, 0, 0, 0, 0, 0, 0, 0, 0);
      cyc(1, 0, 0, 0, 0, 0, 0, 0, 0);
      cyc(1, 0, 0, 0, 0, 0, 0, 0, 0);
      // R7 tied deactivates, R6 pending+active drops to pending
      cyc(0, 1, 9, 0, 0, 0, 0, 0, 0);
      cyc(0, 1, 7, 0, 0, 0, 0, 0, 0);
      cyc(0, 1, 11, 0, 0, 0, 0, 0, 0);
      cyc(0, 1, 5, 0, 0, 0, 0, 0, 0);
      idle(4);
      // R8 miss
      cyc(0, 1, 100, 0, 0, 0, 0, 0, 0);
      idle(2);
      // R5 rejected write leaves entry 0 untouched
      cyc(0, 0, 0, 1, 0, 77, 3, 1, 12);
      idle(4);
      // R9 host write hits the entry being acknowledged
      cyc(1, 0, 0, 1, 3, 20, 2, 1, 21);
      // R9 ack and deact together; deact on the entry being acknowledged counts as a miss
      cyc(0, 0, 0, 1, 0, 30, 1, 0, 0);
      cyc(1, 1, 20, 0, 0, 0, 0, 0, 0);
      cyc(0, 0, 0, 1, 1, 31, 1, 1, 5);
      cyc(1, 1, 31, 0, 0, 0, 0, 0, 0);
      idle(4);
      // pseudo-random traffic over a narrow number range
      lfsr = 16'hACE1;
      for (int k = 0; k < 3000; k++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         cyc(lfsr[0], lfsr[1], int'(lfsr[4:2]), lfsr[5] & lfsr[6], int'(lfsr[8:7]),
             int'(lfsr[11:9]), int'(lfsr[13:12]), lfsr[14], int'(lfsr[15:10]));
      end
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule